// File: doc/BRIEF.md
# Successive-Approximation DC Offset Nulling Controller

This controller removes a large, unknown DC bias from a sensor channel. It closes a digital loop around a level-shifting DAC and an ADC. Starting from half scale, it repeatedly applies a DAC code, lets the analog path settle, averages a block of ADC samples and steps the code by a shrinking binary weight. The front end is inverting, so a positive mean means the code is too low. After sixteen code updates the code that drives the mean ADC input closest to zero is held on the output. The procedure can be rerun at any time to follow drift in the sensor bias or in the common-mode reference.

Samples enter on a valid/ready stream. The block never applies back-pressure: `smp_ready_o` is tied high. A sample counts only when `smp_valid_i` is high on a rising clock edge. Samples offered while no measurement window is open are accepted and dropped. The DAC code leaves as a plain bus with a one-cycle load strobe, and a separate transport module delivers it.

Top module: `dc_null_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `dac_load_o` are low and `dac_code_o` is 0. A `start_i` pulse while idle makes `busy_o` high in the following cycle. In that same cycle `dac_code_o` is 32767 with `dac_load_o` high.
- R2: A run issues exactly 16 load strobes. The first code is 32767. Each later code differs from the one before it by a weight of 2^14, then 2^13, and so on down to 2^0, one weight per step.
- R3: When the averaged error is strictly positive, the weight is added to the code. When the error is zero or negative, the weight is subtracted.
- R4: After each load, the first `settle_cnt_i` accepted samples are discarded. The next 2^AVG_LOG2 samples form the measurement.
- R5: The sign decision comes from the sum of the whole measurement window. Zero-mean noise larger than the error signal therefore does not change the decision.
- R6: `smp_ready_o` is always high. Samples offered while idle, during a load cycle, or after the window is full have no effect.
- R7: A `start_i` pulse while `busy_o` is high is ignored, and the code sequence continues unchanged.
- R8: `done_o` is high for exactly one cycle, the cycle right after the 16th load strobe. `busy_o` is low in that cycle.
- R9: `dac_code_o` changes only in cycles where `dac_load_o` is high. The final code is held until the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a nulling run (ignored while busy) |
| settle_cnt_i | input | SETTLE_W | Samples discarded after each DAC update |
| smp_valid_i | input | 1 | ADC sample valid |
| smp_ready_o | output | 1 | Always high: the block accepts every sample |
| smp_data_i | input | SAMP_W | Signed ADC sample |
| dac_code_o | output | CODE_W | DAC code, held between loads |
| dac_load_o | output | 1 | One-cycle strobe: a new code is on `dac_code_o` |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when a run has finished |

## Verification
The bench models an inverting plant. For a few samples after every load, the plant returns a large negative value, and it then adds alternating-sign noise that dwarfs the true error. A design that skipped the settle discard would pull that garbage into its average and flip decisions. A design that divided or sampled only part of the window would be misled by the noise. One target lands exactly on half scale, which exposes a design that treats a zero mean as positive. Targets below zero and above full scale push every step in one direction. A start pulse injected mid-run would corrupt the code sequence in a design that restarts while busy. The scoreboard compares every loaded code in order, so a wrong weight order, an extra or missing step, or a late done pulse all show up as mismatches.

// File: rtl/dcn_pkg.sv
package dcn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_FIN  = 2'd2
  } dcn_state_e;
endpackage

// File: rtl/dcn_avg.sv
// Settle-skip and power-of-two window accumulator; reports the sign of the sum.
module dcn_avg #(
  parameter int SAMP_W   = 24,
  parameter int AVG_LOG2 = 4,
  parameter int SETTLE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     arm_i,
  input  logic [SETTLE_W-1:0]      settle_i,
  input  logic                     valid_i,
  input  logic signed [SAMP_W-1:0] data_i,
  output logic                     mean_done_o,
  output logic                     mean_pos_o
);
  localparam int ACC_W = SAMP_W + AVG_LOG2 + 1;
  localparam int CNT_W = AVG_LOG2 + 1;
  localparam int NWIN  = 1 << AVG_LOG2;

  logic [SETTLE_W-1:0]     skip_q;
  logic [CNT_W-1:0]        cnt_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_nxt;
  logic                    full_q;
  logic                    done_q;
  logic                    pos_q;
  logic                    take;

  assign take    = arm_i && valid_i && !full_q;
  assign acc_nxt = acc_q + {{(ACC_W-SAMP_W){data_i[SAMP_W-1]}}, data_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_q <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
      full_q <= 1'b0;
      done_q <= 1'b0;
      pos_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clr_i) begin
        skip_q <= settle_i;
        cnt_q  <= '0;
        acc_q  <= '0;
        full_q <= 1'b0;
      end else if (take) begin
        if (skip_q != '0) begin
          skip_q <= skip_q - SETTLE_W'(1);
        end else begin
          acc_q <= acc_nxt;
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(NWIN - 1)) begin
            full_q <= 1'b1;
            done_q <= 1'b1;
            pos_q  <= (acc_nxt > 0);
          end
        end
      end
    end
  end

  assign mean_done_o = done_q;
  assign mean_pos_o  = pos_q;

  AST_ONE_MEAN_PER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mean_done_o |=> !mean_done_o); // R4
endmodule

// File: rtl/dcn_weight_gen.sv
// Produces the shrinking binary weight, one halving per advance.
module dcn_weight_gen #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              adv_i,
  output logic [CODE_W-1:0] weight_o,
  output logic              last_o
);
  localparam int IDX_W = $clog2(CODE_W);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= IDX_W'(CODE_W - 2);
    end else if (restart_i) begin
      idx_q <= IDX_W'(CODE_W - 2);
    end else if (adv_i && idx_q != '0) begin
      idx_q <= idx_q - IDX_W'(1);
    end
  end

  assign weight_o = CODE_W'(1) << idx_q;
  assign last_o   = (idx_q == '0);

  AST_WEIGHT_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !last_o && !restart_i) |=> (weight_o == ($past(weight_o) >> 1))); // R2
endmodule

// File: rtl/dcn_code_step.sv
// Adds or subtracts the weight, clamping at the ends of the code range.
module dcn_code_step #(
  parameter int CODE_W = 16
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] weight_i,
  input  logic              up_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W:0] sum;

  always_comb begin
    sum = {1'b0, code_i} + {1'b0, weight_i};
    if (up_i) begin
      code_o = sum[CODE_W] ? '1 : sum[CODE_W-1:0];
    end else begin
      code_o = (weight_i > code_i) ? '0 : (code_i - weight_i);
    end
  end
endmodule

// File: rtl/dc_null_ctrl.sv
module dc_null_ctrl #(
  parameter int CODE_W   = 16,
  parameter int SAMP_W   = 24,
  parameter int AVG_LOG2 = 4,
  parameter int SETTLE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [SETTLE_W-1:0]      settle_cnt_i,
  input  logic                     smp_valid_i,
  output logic                     smp_ready_o,
  input  logic signed [SAMP_W-1:0] smp_data_i,
  output logic [CODE_W-1:0]        dac_code_o,
  output logic                     dac_load_o,
  output logic                     busy_o,
  output logic                     done_o
);
  import dcn_pkg::*;

  localparam logic [CODE_W-1:0] HALF_CODE = {1'b0, {(CODE_W-1){1'b1}}};

  dcn_state_e        state_q;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_nxt;
  logic [CODE_W-1:0] weight;
  logic              last_step;
  logic              load_q;
  logic              done_q;
  logic              mean_done;
  logic              mean_pos;
  logic              arm;
  logic              launch;
  logic              step_now;

  assign launch   = (state_q == ST_IDLE) && start_i;
  assign arm      = (state_q == ST_MEAS) && !load_q;
  assign step_now = (state_q == ST_MEAS) && mean_done;

  dcn_avg #(
    .SAMP_W  (SAMP_W),
    .AVG_LOG2(AVG_LOG2),
    .SETTLE_W(SETTLE_W)
  ) u_avg (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (load_q),
    .arm_i      (arm),
    .settle_i   (settle_cnt_i),
    .valid_i    (smp_valid_i),
    .data_i     (smp_data_i),
    .mean_done_o(mean_done),
    .mean_pos_o (mean_pos)
  );

  dcn_weight_gen #(
    .CODE_W(CODE_W)
  ) u_wgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(launch),
    .adv_i    (step_now),
    .weight_o (weight),
    .last_o   (last_step)
  );

  dcn_code_step #(
    .CODE_W(CODE_W)
  ) u_step (
    .code_i  (code_q),
    .weight_i(weight),
    .up_i    (mean_pos),
    .code_o  (code_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      load_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      load_q <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            code_q  <= HALF_CODE;
            load_q  <= 1'b1;
            state_q <= ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (mean_done) begin
            code_q <= code_nxt;
            load_q <= 1'b1;
            if (last_step) state_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign smp_ready_o = 1'b1;
  assign dac_code_o  = code_q;
  assign dac_load_o  = load_q;
  assign done_o      = done_q;
  assign busy_o      = (state_q != ST_IDLE);

  AST_RUN_OPENS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (dac_load_o && dac_code_o == HALF_CODE)); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_DONE_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(dac_load_o) && !busy_o)); // R8

  AST_CODE_MOVES_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code_o) |-> dac_load_o); // R9

  AST_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load_o |-> busy_o); // R7
endmodule

// File: tb/dc_null_ctrl_tb.sv
module dc_null_ctrl_tb;
  localparam int LAG = 3;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               start_i;
  logic [11:0]        settle_cnt_i;
  logic               smp_valid_i;
  logic               smp_ready_o;
  logic signed [23:0] smp_data_i;
  logic [15:0]        dac_code_o;
  logic               dac_load_o;
  logic               busy_o;
  logic               done_o;

  always #10 clk = ~clk;

  dc_null_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .settle_cnt_i(settle_cnt_i),
    .smp_valid_i (smp_valid_i),
    .smp_ready_o (smp_ready_o),
    .smp_data_i  (smp_data_i),
    .dac_code_o  (dac_code_o),
    .dac_load_o  (dac_load_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  int checks = 0;
  int fails  = 0;
  int target = 0;
  int loads_in_run = 0;
  bit load_prev = 1'b0;
  logic [15:0] expq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Inverting plant: LAG samples of garbage after each load, then error plus
  // alternating-sign noise much larger than the error.
  initial begin : plant
    int since;
    bit phase;
    bit nsign;
    since = LAG;
    phase = 1'b0;
    nsign = 1'b0;
    smp_valid_i = 1'b0;
    smp_data_i  = '0;
    forever begin
      @(negedge clk);
      if (dac_load_o) since = 0;
      phase = ~phase;
      if (phase) begin
        smp_valid_i = 1'b1;
        if (since < LAG) begin
          smp_data_i = -24'sd8000000;
        end else begin
          nsign = ~nsign;
          smp_data_i = 24'((target - int'(dac_code_o)) * 4 + (nsign ? 3000000 : -3000000));
        end
        since++;
      end else begin
        smp_valid_i = 1'b0;
      end
    end
  end

  // Monitor: pops expected codes as loads appear, checks done timing.
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (dac_load_o) begin
          loads_in_run++;
          if (expq.size() == 0) begin
            check(1'b0, "R2 unexpected load", int'(dac_code_o), -1);
          end else begin
            logic [15:0] e;
            e = expq.pop_front();
            check(dac_code_o == e, "R2/R3 loaded code", int'(dac_code_o), int'(e));
          end
        end
        if (done_o) begin
          check(load_prev, "R8 done right after last load", int'(load_prev), 1);
          check(loads_in_run == 16, "R2 load count", loads_in_run, 16);
          check(!busy_o, "R8 busy low with done", int'(busy_o), 0);
        end
        load_prev = dac_load_o;
      end
    end
  end

  task automatic run(input int tgt, input int settle, input bit poke);
    int c;
    int guard;
    int dones;
    target = tgt;
    settle_cnt_i = 12'(settle);
    c = 32767;
    expq.push_back(16'(c));
    for (int b = 14; b >= 0; b--) begin
      if (tgt - c > 0) c = c + (1 << b);
      else c = c - (1 << b);
      expq.push_back(16'(c));
    end
    loads_in_run = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && dac_load_o && dac_code_o == 16'd32767, "R1 start opens at half scale",
          int'(dac_code_o), 32767);
    if (poke) begin
      repeat (150) @(negedge clk);
      start_i = 1'b1;  // R7: must be ignored
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    dones = 0;
    while (!done_o && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (done_o) dones++;
    repeat (6) begin
      @(negedge clk);
      if (done_o) dones++;
    end
    check(dones == 1, "R8 single done pulse", dones, 1);
    check(!busy_o, "R8 idle after run", int'(busy_o), 0);
    check(dac_code_o == 16'(c), "R9 final code held", int'(dac_code_o), c);
    check(expq.size() == 0, "R2 all codes loaded", expq.size(), 0);
    expq.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    start_i = 1'b0;
    settle_cnt_i = 12'd3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && !dac_load_o && dac_code_o == 16'd0,
          "R1 reset state", int'(dac_code_o), 0);
    check(smp_ready_o, "R6 ready always high", int'(smp_ready_o), 1);
    repeat (20) @(negedge clk);
    check(!dac_load_o && dac_code_o == 16'd0, "R6 idle samples ignored", int'(dac_code_o), 0);
    run(40000, LAG, 1'b0);   // R4 settle equal to plant lag, R5 noise
    run(1000, LAG, 1'b0);
    run(32767, LAG, 1'b0);   // R3 zero mean subtracts
    run(70000, 10, 1'b0);    // R3 every step adds
    run(-500, LAG, 1'b0);    // R3 every step subtracts
    run(12345, 7, 1'b1);     // R7 start while busy
    check(smp_ready_o, "R6 ready after runs", int'(smp_ready_o), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule